// File: doc/BRIEF.md
# I2C Target Port with Address Match

This block is the slave side of a two-wire I2C bus. It runs entirely in the system clock domain and oversamples the SCL and SDA pins through a short synchroniser. From the synchronised levels it derives clock edges and the START and STOP conditions. After a START it shifts in an address byte on rising SCL edges. It compares the upper seven bits with a programmable device address and, when the byte is accepted, pulls SDA low during the ninth clock. Both pin outputs are open-drain and are given as drive-low enables.

As a receiver, each accepted byte is copied into a single holding register, so software can read one byte while the next is arriving. A byte that arrives while the holding register is still full, or while the overflow flag is still set, is dropped and not acknowledged. As a transmitter, the port holds SCL low after each acknowledged byte. Software loads the next byte into the transmit shifter and then pulses a release input to let the clock go. A not-acknowledge from the master ends the read. Status outputs report buffer full, overflow, data versus address, read versus write, the most recent bus condition and a sticky interrupt.

Top module: `i2c_tgt_port`

## Requirements
- R1: After reset, and while `enable` is low, `buf_full`, `ovf`, `is_data`, `is_read`, `start_seen`, `stop_seen` and `irq` are 0, and neither `scl_drive_low` nor `sda_drive_low` is asserted.
- R2: `start_seen` is 1 and `stop_seen` is 0 after a START, which is SDA falling while SCL is high. After a STOP, which is SDA rising while SCL is high, the two are the other way round. They are never both 1.
- R3: An address byte, sent MSB first with the read/write bit in bit 0, is acknowledged only when its bits 7:1 equal `dev_addr`. On a mismatch the port drives no ACK, sets no interrupt and leaves the holding register untouched.
- R4: An accepted byte is copied to `buf_rdata` and `buf_full` is set at the eighth falling SCL edge. `is_data` becomes 0 for an address byte and 1 for a data byte. `is_read` takes bit 0 of a matched address byte (1 means read).
- R5: A matched address byte or a data byte that completes while `buf_full` or `ovf` is 1 is neither transferred nor acknowledged. `ovf` is set if `buf_full` was 1 and `ovf` was 0; otherwise `ovf` is unchanged.
- R6: `irq` is set at the ninth falling SCL edge of every matched address byte and every data byte, whether or not it was acknowledged. It stays set until `irq_clr` is pulsed.
- R7: After acknowledging a read address, and after each transmitted byte that the master acknowledges, the port holds SCL low. It keeps holding SCL low until `release_set` is pulsed. `buf_wr` while SCL is held loads the next transmit byte.
- R8: Transmitted bits leave MSB first, change only after a falling SCL edge, and stay stable while SCL is high.
- R9: A not-acknowledge (SDA high on the ninth rising edge) after a transmitted byte ends the transfer. The port then drives neither line and ignores the bus until the next START.
- R10: A START that arrives part-way through a byte discards the partial byte and restarts address reception.
- R11: Pulsing `buf_rd` clears `buf_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Port enable; low clears all state |
| dev_addr | input | 7 | Device address to match |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level |
| scl_drive_low | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Pull SDA low (ACK or data 0) |
| buf_wr | input | 1 | Load transmit byte (one-cycle pulse) |
| buf_wdata | input | 8 | Transmit byte |
| buf_rd | input | 1 | Read strobe; clears buffer full |
| release_set | input | 1 | Release a stretched SCL |
| ovf_clr | input | 1 | Clear overflow flag |
| irq_clr | input | 1 | Clear interrupt flag |
| buf_rdata | output | 8 | Holding register contents |
| buf_full | output | 1 | Holding register full |
| ovf | output | 1 | Receive overflow |
| is_data | output | 1 | Last byte was data (1) or address (0) |
| is_read | output | 1 | Read/write bit of last matched address |
| start_seen | output | 1 | Last bus condition was START |
| stop_seen | output | 1 | Last bus condition was STOP |
| irq | output | 1 | Sticky interrupt flag |

## Verification
Assertions watch properties that must hold on every cycle. The START and STOP flags are never both set. Disabling the port releases both lines. A completed byte that finds the buffer full or overflowed is never acknowledged. A read strobe empties the buffer. A stretched clock stays held until release. The transmit bit never moves while SCL is high. Other behaviours need whole bus transactions and can only be shown by the bench's scenarios: the address compare against several patterns, the accept/ACK/overflow matrix across consecutive bytes, the read sequence with clock stretching and the master's NACK, and the restart of address reception after a repeated START in mid-byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } tgt_st_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_pin,
  input  logic sda_pin,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] pins, lvl, prev;
  assign pins = {sda_pin, scl_pin};

  // index 0 = SCL, index 1 = SDA; both idle high out of reset
  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              last_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain  <= '1;
        last_q <= 1'b1;
      end else begin
        chain  <= {chain[STAGES-2:0], pins[g]};
        last_q <= chain[STAGES-1];
      end
    end
    assign lvl[g]  = chain[STAGES-1];
    assign prev[g] = last_q;
  end

  assign scl_lvl   = lvl[0];
  assign sda_lvl   = lvl[1];
  assign scl_rise  = lvl[0] & ~prev[0];
  assign scl_fall  = ~lvl[0] & prev[0];
  assign start_det = lvl[0] & prev[0] & prev[1] & ~lvl[1];
  assign stop_det  = lvl[0] & prev[0] & ~prev[1] & lvl[1];
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int DW    = ADDR_W + 1,
  localparam int CNT_W = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          scl_lvl,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic          accept,
  input  logic          buf_wr,
  input  logic [DW-1:0] buf_wdata,
  input  logic          release_set,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte,
  output logic          rx_is_addr,
  output logic          irq_set,
  output logic          tx_done,
  output logic          sda_drive,
  output logic          scl_hold
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DW);
  localparam logic [CNT_W-1:0] TX_LAST = CNT_W'(DW - 1);

  tgt_st_e          st;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    sr, txsr;
  logic             ack_q, hold_q, mack_q, is_addr_q, rw_q;
  logic             match;

  assign match      = (sr[DW-1:1] == dev_addr);
  assign byte_done  = (st == ST_RECV) && scl_fall && (cnt == LAST) && (!is_addr_q || match);
  assign rx_byte    = sr;
  assign rx_is_addr = is_addr_q;
  assign irq_set    = scl_fall && ((st == ST_ACK) || (st == ST_TXACK));
  assign tx_done    = scl_fall && (st == ST_TXACK);
  assign sda_drive  = ((st == ST_ACK) && ack_q) || ((st == ST_TX) && !txsr[DW-1]);
  assign scl_hold   = hold_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      st <= ST_IDLE; cnt <= '0; sr <= '0; txsr <= '1;
      ack_q <= 1'b0; hold_q <= 1'b0; mack_q <= 1'b0; is_addr_q <= 1'b0; rw_q <= 1'b0;
    end else if (start_det) begin
      st <= ST_RECV; cnt <= '0; is_addr_q <= 1'b1;
      ack_q <= 1'b0; hold_q <= 1'b0; txsr <= '1;
    end else if (stop_det) begin
      st <= ST_IDLE; ack_q <= 1'b0; hold_q <= 1'b0; txsr <= '1;
    end else begin
      case (st)
        ST_RECV: begin
          if (scl_rise) begin
            sr  <= {sr[DW-2:0], sda_lvl};
            cnt <= cnt + 1'b1;
          end
          if (scl_fall && cnt == LAST) begin
            if (is_addr_q && !match) st <= ST_IDLE;
            else begin
              st    <= ST_ACK;
              ack_q <= accept;
              if (is_addr_q) rw_q <= sr[0];
            end
          end
        end
        ST_ACK: if (scl_fall) begin
          ack_q <= 1'b0;
          cnt   <= '0;
          if (is_addr_q && !ack_q) st <= ST_IDLE;
          else if (is_addr_q && rw_q) begin
            st <= ST_TX; hold_q <= 1'b1; txsr <= '1;
          end else begin
            st <= ST_RECV; is_addr_q <= 1'b0;
          end
        end
        ST_TX: begin
          if (hold_q) begin
            if (buf_wr) txsr <= buf_wdata;
            if (release_set) hold_q <= 1'b0;
          end else if (scl_fall) begin
            txsr <= {txsr[DW-2:0], 1'b1};
            cnt  <= cnt + 1'b1;
            if (cnt == TX_LAST) st <= ST_TXACK;
          end
        end
        ST_TXACK: begin
          if (scl_rise) mack_q <= ~sda_lvl;
          if (scl_fall) begin
            cnt <= '0;
            if (mack_q) begin
              st <= ST_TX; hold_q <= 1'b1; txsr <= '1;
            end else st <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  // R7: a stretched clock stays held until software releases it
  a_r7_hold_until_release: assert property (@(posedge clk) disable iff (rst)
    (hold_q && !release_set && enable && !start_det && !stop_det) |=> hold_q);

  // R8: the transmit bit does not move while SCL is high
  a_r8_tx_stable_high: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TX && $past(st) == ST_TX && scl_lvl && !scl_rise) |-> $stable(txsr[DW-1]));
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          byte_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_is_addr,
  input  logic          irq_set,
  input  logic          tx_done,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          buf_rd,
  input  logic          ovf_clr,
  input  logic          irq_clr,
  output logic          accept,
  output logic [DW-1:0] buf_rdata,
  output logic          buf_full,
  output logic          ovf,
  output logic          is_data,
  output logic          is_read,
  output logic          start_seen,
  output logic          stop_seen,
  output logic          irq
);
  assign accept = !buf_full && !ovf;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      buf_rdata <= '0; buf_full <= 1'b0; ovf <= 1'b0; is_data <= 1'b0;
      is_read <= 1'b0; start_seen <= 1'b0; stop_seen <= 1'b0; irq <= 1'b0;
    end else begin
      if (buf_rd)  buf_full <= 1'b0;
      if (ovf_clr) ovf <= 1'b0;
      if (irq_clr) irq <= 1'b0;
      if (irq_set) irq <= 1'b1;
      if (tx_done) is_data <= 1'b1;
      if (byte_done) begin
        is_data <= !rx_is_addr;
        if (rx_is_addr) is_read <= rx_byte[0];
        if (accept) begin
          buf_rdata <= rx_byte;
          buf_full  <= 1'b1;
        end else if (buf_full && !ovf) ovf <= 1'b1;
      end
      if (start_det) begin
        start_seen <= 1'b1; stop_seen <= 1'b0;
      end else if (stop_det) begin
        start_seen <= 1'b0; stop_seen <= 1'b1;
      end
    end
  end

  // R11: a read strobe empties the holding register
  a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
    (buf_rd && !byte_done && enable) |=> !buf_full);

  // R2: the two condition flags never coexist
  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(start_seen && stop_seen));
endmodule

// File: rtl/i2c_tgt_port.sv
module i2c_tgt_port #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2,
  localparam int DW         = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  input  logic              buf_wr,
  input  logic [DW-1:0]     buf_wdata,
  input  logic              buf_rd,
  input  logic              release_set,
  input  logic              ovf_clr,
  input  logic              irq_clr,
  output logic [DW-1:0]     buf_rdata,
  output logic              buf_full,
  output logic              ovf,
  output logic              is_data,
  output logic              is_read,
  output logic              start_seen,
  output logic              stop_seen,
  output logic              irq
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic accept, byte_done, rx_is_addr, irq_set, tx_done;
  logic [DW-1:0] rx_byte;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_pin(scl_in), .sda_pin(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  i2c_tgt_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk(clk), .rst(rst), .enable(enable),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .dev_addr(dev_addr), .accept(accept),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .release_set(release_set),
    .byte_done(byte_done), .rx_byte(rx_byte), .rx_is_addr(rx_is_addr),
    .irq_set(irq_set), .tx_done(tx_done), .sda_drive(sda_drive_low), .scl_hold(scl_drive_low));

  i2c_tgt_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .enable(enable), .byte_done(byte_done), .rx_byte(rx_byte),
    .rx_is_addr(rx_is_addr), .irq_set(irq_set), .tx_done(tx_done),
    .start_det(start_det), .stop_det(stop_det), .buf_rd(buf_rd), .ovf_clr(ovf_clr),
    .irq_clr(irq_clr), .accept(accept), .buf_rdata(buf_rdata), .buf_full(buf_full),
    .ovf(ovf), .is_data(is_data), .is_read(is_read), .start_seen(start_seen),
    .stop_seen(stop_seen), .irq(irq));

  // R1: a disabled port lets go of both lines
  a_r1_disable_release: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!sda_drive_low && !scl_drive_low));

  // R5: a byte refused by the buffer flags gets no ACK
  a_r5_no_ack_when_blocked: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !accept) |=> !sda_drive_low);
endmodule

// File: tb/sim_i2c_tgt_port.sv
module sim_i2c_tgt_port;
  localparam int Q = 8;
  localparam logic [6:0] MY_ADDR = 7'h2C;
  // {expect_ack, address[6:0], data[7:0]}
  localparam logic [15:0] VEC [0:5] = '{16'hAC5A, 16'h2D00, 16'hACFF, 16'h6C11, 16'hAC00, 16'h0C77};

  logic clk = 1'b0, rst = 1'b1, enable = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic buf_wr = 1'b0, buf_rd = 1'b0, release_set = 1'b0, ovf_clr = 1'b0, irq_clr = 1'b0;
  logic [7:0] buf_wdata = 8'h00;
  logic scl_drive_low, sda_drive_low, buf_full, ovf, is_data, is_read, start_seen, stop_seen, irq;
  logic [7:0] buf_rdata;
  wire scl_bus = scl_m & ~scl_drive_low;
  wire sda_bus = sda_m & ~sda_drive_low;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  i2c_tgt_port u0 (
    .clk(clk), .rst(rst), .enable(enable), .dev_addr(MY_ADDR),
    .scl_in(scl_bus), .sda_in(sda_bus), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rd(buf_rd), .release_set(release_set),
    .ovf_clr(ovf_clr), .irq_clr(irq_clr), .buf_rdata(buf_rdata), .buf_full(buf_full),
    .ovf(ovf), .is_data(is_data), .is_read(is_read), .start_seen(start_seen),
    .stop_seen(stop_seen), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: buf_rd = 1'b1; 1: buf_wr = 1'b1; 2: release_set = 1'b1;
      3: ovf_clr = 1'b1; default: irq_clr = 1'b1;
    endcase
    @(negedge clk);
    buf_rd = 1'b0; buf_wr = 1'b0; release_set = 1'b0; ovf_clr = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic clock_bit(input logic b, output logic s, output logic stable);
    logic a;
    sda_m = b;
    wait_clk(Q);
    scl_m = 1'b1;
    do @(negedge clk); while (!scl_bus);
    wait_clk(Q);
    a = sda_bus;
    wait_clk(Q);
    s = sda_bus;
    stable = (a == s);
    scl_m = 1'b0;
    wait_clk(Q);
  endtask

  task automatic do_start();
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1;
    do @(negedge clk); while (!scl_bus);
    wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1;
    do @(negedge clk); while (!scl_bus);
    wait_clk(Q);
    sda_m = 1'b1; wait_clk(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic s, st;
    for (int i = 7; i >= 0; i--) clock_bit(v[i], s, st);
    clock_bit(1'b1, s, st);
    ack = !s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v, output logic stab);
    logic s, st;
    stab = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s, st);
      v[i] = s;
      stab &= st;
    end
    clock_bit(!mack, s, st);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic ack, stab;
    logic [7:0] rv;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    // R1: reset state
    chk("R1 reset flags", {buf_full, ovf, is_data, is_read, start_seen, stop_seen, irq}, 0);
    chk("R1 reset drives", {scl_drive_low, sda_drive_low}, 0);
    enable = 1'b1;
    wait_clk(4);

    // table walk: write transactions against several addresses
    for (int k = 0; k < 6; k++) begin
      do_start();
      chk("R2 start flags", {start_seen, stop_seen}, 2'b10);
      send_byte({VEC[k][14:8], 1'b0}, ack);
      chk("R3 address ack", ack, VEC[k][15]);
      if (VEC[k][15]) begin
        chk("R4 address buffered", {buf_full, buf_rdata}, {1'b1, VEC[k][14:8], 1'b0});
        chk("R4 address kind", {is_data, is_read}, 2'b00);
        chk("R6 irq on address", irq, 1);
        pulse(4);
        chk("R6 irq cleared", irq, 0);
        pulse(0);
        send_byte(VEC[k][7:0], ack);
        chk("R4 data ack", ack, 1);
        chk("R4 data buffered", {buf_full, is_data, buf_rdata}, {2'b11, VEC[k][7:0]});
        pulse(0);
        chk("R11 read clears", buf_full, 0);
        pulse(4);
      end else begin
        chk("R3 mismatch no irq", irq, 0);
        chk("R3 mismatch buffer", buf_full, 0);
      end
      do_stop();
      chk("R2 stop flags", {start_seen, stop_seen}, 2'b01);
    end

    // R5: overflow matrix
    do_start();
    send_byte({MY_ADDR, 1'b0}, ack);
    pulse(0); pulse(4);
    send_byte(8'h31, ack);
    chk("R5 first byte acked", ack, 1);
    pulse(4);
    send_byte(8'h32, ack);
    chk("R5 full byte nack", ack, 0);
    chk("R5 overflow set", {ovf, buf_full, buf_rdata}, {2'b11, 8'h31});
    chk("R6 irq despite nack", irq, 1);
    pulse(4);
    pulse(0);
    chk("R11 read clears with ovf", {buf_full, ovf}, 2'b01);
    send_byte(8'h33, ack);
    chk("R5 ovf-only nack", ack, 0);
    chk("R5 ovf-only no transfer", {ovf, buf_full, buf_rdata}, {2'b10, 8'h31});
    chk("R6 irq on ovf byte", irq, 1);
    pulse(3); pulse(4);
    send_byte(8'h34, ack);
    chk("R5 cleared accepts", {ack, buf_full, buf_rdata}, {2'b11, 8'h34});
    pulse(0); pulse(4);
    do_stop();

    // R7, R8, R9: read transfer
    do_start();
    send_byte({MY_ADDR, 1'b1}, ack);
    chk("R3 read address ack", ack, 1);
    chk("R4 read bit", {is_read, is_data}, 2'b10);
    pulse(0); pulse(4);
    wait_clk(40);
    chk("R7 clock held", scl_drive_low, 1);
    buf_wdata = 8'hA5; pulse(1);
    pulse(2);
    recv_byte(1'b1, rv, stab);
    chk("R8 first tx byte", rv, 8'hA5);
    chk("R8 stable while high", stab, 1);
    chk("R7 held after master ack", scl_drive_low, 1);
    chk("R6 irq after tx byte", {irq, is_data}, 2'b11);
    pulse(4);
    buf_wdata = 8'h3C; pulse(1);
    pulse(2);
    recv_byte(1'b0, rv, stab);
    chk("R8 second tx byte", {rv, stab}, {8'h3C, 1'b1});
    chk("R9 released after nack", {scl_drive_low, sda_drive_low}, 2'b00);
    send_byte(8'h00, ack);
    chk("R9 ignored until start", {ack, scl_drive_low}, 2'b00);
    do_stop();
    pulse(4);

    // R10: repeated START in mid-byte
    do_start();
    for (int i = 0; i < 3; i++) begin
      logic s, st;
      clock_bit(1'b0, s, st);
    end
    do_start();
    chk("R10 restart flags", {start_seen, stop_seen}, 2'b10);
    send_byte({MY_ADDR, 1'b0}, ack);
    chk("R10 address after restart", {ack, buf_rdata}, {1'b1, MY_ADDR, 1'b0});
    pulse(0); pulse(4);

    // R1: disable clears the flags and lets go of the lines
    send_byte(8'h55, ack);
    chk("R1 setup flags", {buf_full, irq}, 2'b11);
    @(negedge clk) enable = 1'b0;
    wait_clk(3);
    chk("R1 disabled flags", {buf_full, ovf, is_data, is_read, start_seen, stop_seen, irq}, 0);
    chk("R1 disabled drives", {scl_drive_low, sda_drive_low}, 0);
    @(negedge clk) enable = 1'b1;
    do_stop();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule